// File: doc/BRIEF.md
# Serial Memory Status Register Controller

This block implements the status-register side of a serial memory command port. A host frames each command by pulling an active-low select line low and shifting bits in on one serial data line, most significant bit first, one bit per rising clock edge. Three commands are understood:

- **Set-write-enable** arms the write latch.
- **Status write** loads new protection settings.
- **Status read** streams the status byte back on a serial output.

An accepted status write starts a self-timed update cycle whose length in clock cycles is a parameter. While that cycle runs, a busy flag reads as 1 and only status reads are served. The new protection settings take effect when the cycle ends, and the write latch clears at the same moment.

A sticky write-disable bit works together with an external active-low write-protect pin to lock the protection settings in hardware. The serial output has a separate enable signal, so the surrounding logic can model a floating pin whenever no read is streaming.

Top module: `sr_status_ctrl`

## Requirements
- R1: A frame of exactly 8 bits carrying code 0x06, ended while no update cycle runs, sets the write latch (status bit 1). A frame with that code and any other length has no effect.
- R2: A status write (code 0x01 followed by one data byte) is accepted only when the write latch is already 1. Otherwise it changes nothing and starts no cycle.
- R3: A status write is accepted only if select rises when exactly 16 bits have been shifted in. A frame of 15 or 17 bits is discarded.
- R4: An accepted write sets the busy flag (status bit 0) for exactly TW_CYCLES clocks, starting on the clock after the select rise is sampled. The flag then returns to 0.
- R5: When the cycle ends, the write latch clears and the written data takes effect. Data bit 7 becomes the write-disable bit (status bit 7) and data bits 5..2 become the protection field (status bits 5..2). Data bits 6, 1 and 0 are ignored, and status bit 6 always reads 0.
- R6: While the write-disable bit is 1 and wp_n is low, a status write is ignored. No cycle starts and the write latch keeps its value.
- R7: While the busy flag is 1, set-write-enable and status-write frames are ignored, and status reads are still served.
- R8: After the eighth bit of code 0x05 is sampled, the live status byte is driven on sdo, most significant bit first. Each bit changes on a falling clock edge, and the byte repeats for as long as select stays low. sdo_oe is 1 while this stream runs.
- R9: sdo_oe stays 0 throughout status-write and set-write-enable frames.
- R10: After reset the status byte reads 0x00 and sdo_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial and timing clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial command and data input, sampled on the rising edge |
| wp_n | input | 1 | Active-low hardware write-protect pin |
| sdo | output | 1 | Serial status output, changes on the falling edge |
| sdo_oe | output | 1 | Output enable for sdo; 0 means the pin floats |

## Verification
Embedded assertions check these properties on every cycle:

- Every busy period lasts exactly TW_CYCLES clocks.
- A cycle only starts with the write latch set.
- The latch is clear whenever busy falls.
- The protection bits change only at the end of a cycle.
- A 16-bit frame under hardware protection neither starts a cycle nor disturbs the latch.
- Frames that end during a cycle leave the pending data untouched.

The directed scenarios show what only the serial port can reveal:

- The bit order and falling-edge timing of the read stream, and its repetition within one frame.
- sdo_oe staying low during write frames.
- The 15- and 17-bit frames being discarded.
- The masking of data bits 6, 1 and 0.
- A write sent during a cycle leaving no trace once the cycle ends.

// File: rtl/sr_stat_pkg.sv
package sr_stat_pkg;

    localparam int BYTE_W  = 8;
    localparam int FRAME_W = 2 * BYTE_W;

    typedef enum logic [BYTE_W-1:0] {
        OP_ARM   = 8'h06,
        OP_WRITE = 8'h01,
        OP_READ  = 8'h05
    } opcode_e;

    // Bit positions are part of the behaviour: the host decodes them.
    typedef struct packed {
        logic       lock;   // bit 7, sticky write-disable
        logic       rsvd;   // bit 6, reads 0
        logic [3:0] prot;   // bits 5..2
        logic       armed;  // bit 1, write latch
        logic       busy;   // bit 0, update cycle running
    } status_t;

    function automatic status_t make_status(logic lock, logic [3:0] prot,
                                            logic armed, logic busy);
        status_t s;
        s.lock  = lock;
        s.rsvd  = 1'b0;
        s.prot  = prot;
        s.armed = armed;
        s.busy  = busy;
        return s;
    endfunction

endpackage

// File: rtl/sr_frame_rx.sv
module sr_frame_rx #(
    parameter int FRAME_BITS = 16,
    parameter int CNT_W      = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cs_n,
    input  logic                  sdi,
    output logic                  frame_end,
    output logic [CNT_W-1:0]      bit_cnt,
    output logic [FRAME_BITS-1:0] shreg
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic                  cs_seen_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [FRAME_BITS-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_seen_q <= 1'b1;
            cnt_q     <= '0;
            sh_q      <= '0;
        end else begin
            cs_seen_q <= cs_n;
            if (cs_n) begin
                cnt_q <= '0;
            end else begin
                if (cnt_q != CNT_MAX)
                    cnt_q <= cnt_q + 1'b1;
                sh_q <= {sh_q[FRAME_BITS-2:0], sdi};
            end
        end
    end

    assign frame_end = cs_n & ~cs_seen_q;
    assign bit_cnt   = cnt_q;
    assign shreg     = sh_q;

    // R3
    idle_count_chk: assert property (@(posedge clk) disable iff (rst)
        cs_seen_q |-> (cnt_q == '0));

endmodule

// File: rtl/sr_write_timer.sv
module sr_write_timer #(
    parameter int TW_CYCLES = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int TW_W = $clog2(TW_CYCLES + 1);
    localparam logic [TW_W-1:0] TW_LOAD = TW_W'(TW_CYCLES);
    localparam logic [TW_W-1:0] TW_ONE  = TW_W'(1);

    logic            busy_q;
    logic [TW_W-1:0] left_q;

    assign done = busy_q && (left_q == TW_ONE);
    assign busy = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            left_q <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            left_q <= TW_LOAD;
        end else if (done) begin
            busy_q <= 1'b0;
            left_q <= '0;
        end else if (busy_q) begin
            left_q <= left_q - 1'b1;
        end
    end

    // R7
    start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy_q);

endmodule

// File: rtl/sr_read_tx.sv
module sr_read_tx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         active,
    input  logic [W-1:0] word,
    output logic         sdo
);
    localparam int IDX_W = $clog2(W);
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(W - 1);

    logic [IDX_W-1:0] idx_q;
    logic             sdo_q;

    always_ff @(negedge clk) begin
        if (rst || !active) begin
            idx_q <= IDX_TOP;
            sdo_q <= 1'b0;
        end else begin
            sdo_q <= word[idx_q];
            idx_q <= (idx_q == '0) ? IDX_TOP : idx_q - 1'b1;
        end
    end

    assign sdo = sdo_q;

endmodule

// File: rtl/sr_status_ctrl.sv
module sr_status_ctrl
    import sr_stat_pkg::*;
#(
    parameter int TW_CYCLES = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sdi,
    input  logic wp_n,
    output logic sdo,
    output logic sdo_oe
);
    localparam int CNT_W = $clog2(FRAME_W + 2) + 1;
    localparam logic [CNT_W-1:0] CNT_CMD  = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam int RUN_W = $clog2(TW_CYCLES + 2) + 1;

    logic               frame_end;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] shreg;
    logic               busy, tmr_done;

    logic       lock_q, armed_q, rd_act_q;
    logic [3:0] prot_q;
    logic       pend_lock_q;
    logic [3:0] pend_prot_q;

    logic    hw_locked, arm_go, write_go, rd_start;
    status_t status;

    sr_frame_rx #(.FRAME_BITS(FRAME_W), .CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sdi(sdi),
        .frame_end(frame_end), .bit_cnt(bit_cnt), .shreg(shreg)
    );

    sr_write_timer #(.TW_CYCLES(TW_CYCLES)) u_tmr (
        .clk(clk), .rst(rst), .start(write_go), .busy(busy), .done(tmr_done)
    );

    assign hw_locked = lock_q & ~wp_n;

    assign arm_go   = frame_end && (bit_cnt == CNT_CMD) &&
                      (shreg[BYTE_W-1:0] == OP_ARM) && !busy;

    assign write_go = frame_end && (bit_cnt == CNT_FULL) &&
                      (shreg[FRAME_W-1:BYTE_W] == OP_WRITE) &&
                      armed_q && !busy && !hw_locked;

    assign rd_start = !cs_n && (bit_cnt == CNT_LAST) &&
                      ({shreg[BYTE_W-2:0], sdi} == OP_READ);

    assign status = make_status(lock_q, prot_q, armed_q, busy);

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q      <= 1'b0;
            prot_q      <= '0;
            armed_q     <= 1'b0;
            rd_act_q    <= 1'b0;
            pend_lock_q <= 1'b0;
            pend_prot_q <= '0;
        end else begin
            if (cs_n)
                rd_act_q <= 1'b0;
            else if (rd_start)
                rd_act_q <= 1'b1;

            if (arm_go)
                armed_q <= 1'b1;
            else if (tmr_done)
                armed_q <= 1'b0;

            if (write_go) begin
                pend_lock_q <= shreg[7];
                pend_prot_q <= shreg[5:2];
            end

            if (tmr_done) begin
                lock_q <= pend_lock_q;
                prot_q <= pend_prot_q;
            end
        end
    end

    sr_read_tx #(.W(BYTE_W)) u_tx (
        .clk(clk), .rst(rst), .active(rd_act_q), .word(status), .sdo(sdo)
    );

    assign sdo_oe = rd_act_q & ~cs_n;

    // Checker state: length of the current busy run.
    logic [RUN_W-1:0] busy_run_q;
    always_ff @(posedge clk) begin
        if (rst || !busy)
            busy_run_q <= '0;
        else
            busy_run_q <= busy_run_q + 1'b1;
    end

    // R4
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_run_q == RUN_W'(TW_CYCLES)));

    // R2
    arm_needed_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> armed_q);

    // R5
    arm_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !armed_q);

    // R5
    prot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable({lock_q, prot_q}) |-> $past(tmr_done));

    // R6
    hw_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_end && hw_locked && !busy && bit_cnt == CNT_FULL)
            |=> (!busy && $stable(armed_q)));

    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_end && busy && !tmr_done)
            |=> ($stable(pend_prot_q) && $stable(pend_lock_q) && busy));

endmodule

// File: tb/sr_status_ctrl_test.sv
module sr_status_ctrl_test;

    localparam int TW = 80;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sdi = 1'b0;
    logic wp_n = 1'b1;
    logic sdo, sdo_oe;

    int checks = 0;
    int failures = 0;
    logic oe_seen = 1'b0;
    logic finished = 1'b0;

    sr_status_ctrl #(.TW_CYCLES(TW)) uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sdi(sdi), .wp_n(wp_n),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    always #2 clk = ~clk;   // 4 ns period, 250 MHz

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Drive one bit just after a rising edge; look at sdo_oe mid-cycle.
    task automatic tx_bit(input logic b);
        @(posedge clk);
        #1;
        cs_n = 1'b0;
        sdi = b;
        #2;
        if (sdo_oe) oe_seen = 1'b1;
    endtask

    task automatic tx_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) tx_bit(v[i]);
    endtask

    task automatic end_frame();
        @(posedge clk);
        #1;
        cs_n = 1'b1;
        sdi = 1'b0;
        @(posedge clk);
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Status read, two bytes in one frame; oe_ok reports sdo_oe held 1.
    task automatic rd_status(output logic [7:0] b0, output logic [7:0] b1,
                             output logic oe_ok);
        oe_ok = 1'b1;
        tx_byte(8'h05);
        for (int k = 0; k < 16; k++) begin
            @(posedge clk);
            #3;
            if (k < 8) b0[7-k] = sdo;
            else       b1[15-k] = sdo;
            if (sdo_oe !== 1'b1) oe_ok = 1'b0;
        end
        end_frame();
    endtask

    task automatic wr_status(input logic [7:0] d, input int nbits);
        tx_byte(8'h01);
        for (int i = 0; i < nbits; i++) tx_bit(i < 8 ? d[7-i] : 1'b0);
        end_frame();
    endtask

    task automatic arm();
        tx_byte(8'h06);
        end_frame();
    endtask

    task automatic t_reset();
        logic [7:0] a, b;
        logic ok;
        #1;
        chk("R10 sdo_oe after reset", {7'd0, sdo_oe}, 8'h00);
        rd_status(a, b, ok);
        chk("R10 status after reset", a, 8'h00);
        chk("R8 sdo_oe during read", {7'd0, ok}, 8'h01);
    endtask

    task automatic t_no_arm();
        logic [7:0] a, b;
        logic ok;
        wr_status(8'hBC, 8);
        rd_status(a, b, ok);
        chk("R2 write without latch, no cycle", a, 8'h00);
        idle(TW + 10);
        rd_status(a, b, ok);
        chk("R2 write without latch, no change", a, 8'h00);
    endtask

    task automatic t_arm();
        logic [7:0] a, b;
        logic ok;
        tx_byte(8'h06);
        tx_bit(1'b0);
        end_frame();
        rd_status(a, b, ok);
        chk("R1 9-bit enable frame ignored", a, 8'h00);
        oe_seen = 1'b0;
        arm();
        chk("R9 sdo_oe low in enable frame", {7'd0, oe_seen}, 8'h00);
        rd_status(a, b, ok);
        chk("R1 latch set", a, 8'h02);
        chk("R8 byte repeats", b, 8'h02);
    endtask

    task automatic t_write();
        logic [7:0] a, b;
        logic ok;
        oe_seen = 1'b0;
        wr_status(8'hFF, 8);
        chk("R9 sdo_oe low in write frame", {7'd0, oe_seen}, 8'h00);
        rd_status(a, b, ok);
        chk("R4 busy during cycle, old bits kept", a, 8'h03);
        idle(TW + 10);
        rd_status(a, b, ok);
        chk("R5 result after cycle, masked bits", a, 8'hBC);
    endtask

    task automatic t_abort();
        logic [7:0] a, b;
        logic ok;
        arm();
        rd_status(a, b, ok);
        chk("R3 armed before short frame", a, 8'hBE);
        wr_status(8'h00, 7);
        idle(TW + 10);
        rd_status(a, b, ok);
        chk("R3 15-bit frame discarded", a, 8'hBE);
        wr_status(8'h00, 9);
        idle(TW + 10);
        rd_status(a, b, ok);
        chk("R3 17-bit frame discarded", a, 8'hBE);
    endtask

    task automatic t_hw_lock();
        logic [7:0] a, b;
        logic ok;
        wp_n = 1'b0;
        wr_status(8'h00, 8);
        rd_status(a, b, ok);
        chk("R6 locked write ignored", a, 8'hBE);
        wp_n = 1'b1;
    endtask

    task automatic t_busy();
        logic [7:0] a, b;
        logic ok;
        wr_status(8'h00, 8);
        rd_status(a, b, ok);
        chk("R7 read served while busy", a, 8'hBF);
        wr_status(8'h9C, 8);
        idle(TW + 10);
        rd_status(a, b, ok);
        chk("R7 write during cycle ignored", a, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_no_arm();
        t_arm();
        t_write();
        t_abort();
        t_hw_lock();
        t_busy();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule